// File: doc/BRIEF.md
# Page Buffer Merge Program Engine

This block collects a page write for a byte-addressed array that can only be reprogrammed one page at a time. A transaction opens with a start address. The upper address bits name the page and the lower eight bits name the first byte slot. Each data byte that follows is captured in a 256-entry staging buffer and marked as loaded. The slot index then advances and wraps inside the page. If more than a page of bytes arrives, later bytes overwrite earlier slots.

On commit, the engine steps through every location of the selected page, one per clock. At each location it writes either the staged byte or the byte already stored there. A busy flag covers the whole operation and stays high for a programmable number of cycles, which stands in for the nonvolatile write time. While busy is high, the block ignores every request. An abort, or a commit with nothing loaded, leaves the array alone and never raises busy.

The array starts erased, with every byte at all ones. A one-cycle read port exposes it so the contents can be observed. The page count is a parameter. The full-size memory uses 9 page bits (512 pages, 131,072 bytes); the default elaborates a reduced 8-page array.

Top module: `page_merge_prog`

## Requirements
- R1: After reset, busy is low and every array byte reads as 8'hFF.
- R2: On txn_start, bits [ADDR_W-1:8] of start_addr select the page and bits [7:0] select the first slot. Each accepted byte_vld stores byte_data at the current slot, and the slot then advances by one.
- R3: The slot index advances from 255 to 0 inside the same page. When more than 256 bytes are loaded, a later byte replaces the earlier byte held in the same slot.
- R4: After a commit with at least one byte loaded, each loaded location of the selected page holds the last byte loaded for it. All other locations, in that page and in every other page, keep their previous values.
- R5: An accepted commit raises busy on the following cycle. Busy then stays high for exactly max(WRITE_CYCLES, 258) consecutive cycles.
- R6: A commit with no byte loaded, and a commit after an abort, leave busy low and the array unchanged.
- R7: While busy is high, txn_start, byte_vld and commit have no effect. No transaction is open afterwards.
- R8: A txn_start inside an open transaction discards the bytes staged so far. Only bytes loaded after the latest txn_start are programmed.
- R9: rd_data shows the array byte at the rd_addr sampled on the previous rising clock edge.
- R10: byte_vld and commit with no open transaction are ignored: busy stays low and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | Open (or restart) a transaction at start_addr |
| start_addr | input | ADDR_W | Page number in the upper bits, first slot in the low 8 bits |
| byte_vld | input | 1 | Load byte_data into the current slot |
| byte_data | input | DATA_W | Data byte to stage |
| commit | input | 1 | Program the staged page |
| abort | input | 1 | Drop the open transaction |
| busy | output | 1 | Page programming in progress |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array byte, one cycle after rd_addr |

## Verification
The hardest state to reach from the ports is a request arriving while the page walk and the timed hold are running. The bench raises a commit and, while busy is still high, sends a full transaction aimed at a different page. It then confirms that only the first page changed and that a later bare commit finds no transaction open. Slot wrap-around needs more than 256 loads from a start near the top of a page. Cross-page isolation is covered by a sweep that programs every page with a different start slot and length, then compares the whole array against an arithmetic model.

// File: rtl/pmp_pkg.sv
// Package for the page merge program engine.
// Holds the control state encoding that the walker uses.
package pmp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no transaction open
        ST_LOAD = 2'd1,   // transaction open, bytes being staged
        ST_WALK = 2'd2,   // stepping through the page, writing merged bytes
        ST_HOLD = 2'd3    // walk finished, waiting out the write time
    } pmp_state_e;
endpackage

// File: rtl/page_array.sv
// Backing byte array. It has one write port and two synchronous read ports.
// Reset fills every location with all ones (the erased state).
// A read of the address being written in the same cycle returns the old byte.
module page_array #(
    parameter int PAGE_AW = 3,
    parameter int IDX_W   = 8,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PAGE_AW+IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [PAGE_AW+IDX_W-1:0]  ra_addr,
    output logic [DATA_W-1:0]         ra_data,
    input  logic [PAGE_AW+IDX_W-1:0]  rb_addr,
    output logic [DATA_W-1:0]         rb_data
);
    localparam int DEPTH = 1 << (PAGE_AW + IDX_W);

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage: erase on reset, otherwise take the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read ports: register the addressed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_data <= '1;
            rb_data <= '1;
        end else begin
            ra_data <= mem[ra_addr];
            rb_data <= mem[rb_addr];
        end
    end
endmodule

// File: rtl/page_buffer.sv
// Staging buffer for one page: a data byte and a loaded flag per slot,
// plus the page number and a slot index that wraps inside the page.
// Opening a transaction clears all flags and latches page and slot.
// clear_i drops the flags only. It assumes open_i and load_i are never
// high together; the controller guarantees this.
module page_buffer #(
    parameter int PAGE_AW = 3,
    parameter int IDX_W   = 8,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      open_i,
    input  logic [PAGE_AW+IDX_W-1:0]  start_addr,
    input  logic                      clear_i,
    input  logic                      load_i,
    input  logic [DATA_W-1:0]         load_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_vld,
    output logic [PAGE_AW-1:0]        page_o,
    output logic                      any_loaded_o
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] ent_data [ENTRIES];
    logic [ENTRIES-1:0] ent_vld;

    // Page and slot pointer: latched on open, slot advances on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            page_o <= '0;
        end else if (open_i) begin
            wr_idx <= start_addr[IDX_W-1:0];
            page_o <= start_addr[PAGE_AW+IDX_W-1:IDX_W];
        end else if (load_i) begin
            wr_idx <= wr_idx + 1'b1;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [DATA_W-1:0] d_q;
        logic              v_q;

        // Slot storage: the flag clears on open/clear and sets when the slot is loaded.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (open_i || clear_i) begin
                v_q <= 1'b0;
            end else if (load_i && wr_idx == IDX_W'(e)) begin
                d_q <= load_data;
                v_q <= 1'b1;
            end
        end

        assign ent_data[e] = d_q;
        assign ent_vld[e]  = v_q;
    end

    assign rd_data      = ent_data[rd_idx];
    assign rd_vld       = ent_vld[rd_idx];
    assign any_loaded_o = |ent_vld;

    // R2/R3: each load moves the slot by one, modulo the page size
    a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !open_i) |=> wr_idx == IDX_W'($past(wr_idx) + 1'b1));

    // R8: a new transaction starts with no slot marked loaded
    a_r8_open_clears: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |=> !any_loaded_o);
endmodule

// File: rtl/merge_walker.sv
// Transaction control and the commit walk.
// In the load phase it gates the buffer's open/clear/load strobes.
// On an accepted commit it steps a slot counter through the whole page,
// one slot per clock. Each slot is read from the array and the buffer
// in the same cycle, and the merged byte is written on the next cycle.
// A counter holds busy for EFF_CYCLES in total.
// It assumes EFF_CYCLES covers the walk, which takes ENTRIES+1 cycles.
module merge_walker
    import pmp_pkg::*;
#(
    parameter int PAGE_AW      = 3,
    parameter int IDX_W        = 8,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 300
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      txn_start,
    input  logic                      abort,
    input  logic                      commit,
    input  logic                      byte_vld,
    input  logic                      any_loaded,
    input  logic [DATA_W-1:0]         buf_rd_data,
    input  logic                      buf_rd_vld,
    input  logic [DATA_W-1:0]         old_data,
    input  logic [PAGE_AW-1:0]        page,
    output logic                      buf_open,
    output logic                      buf_clear,
    output logic                      buf_load,
    output logic [IDX_W-1:0]          walk_slot,
    output logic                      arr_wr_en,
    output logic [PAGE_AW+IDX_W-1:0]  arr_wr_addr,
    output logic [DATA_W-1:0]         arr_wr_data,
    output logic                      busy
);
    localparam int ENTRIES    = 1 << IDX_W;
    localparam int MIN_CYCLES = ENTRIES + 2;
    localparam int EFF_CYCLES = (WRITE_CYCLES < MIN_CYCLES) ? MIN_CYCLES : WRITE_CYCLES;
    localparam int CNT_W      = $clog2(EFF_CYCLES);

    pmp_state_e        state;
    logic [CNT_W-1:0]  busy_cnt;
    logic [IDX_W:0]    walk_idx;
    logic              pend_vld;
    logic              pend_use;
    logic [IDX_W-1:0]  pend_idx;
    logic [DATA_W-1:0] pend_new;
    logic              in_load;
    logic              go;
    logic              cnt_last;
    logic              walk_end;

    assign busy      = (state == ST_WALK) || (state == ST_HOLD);
    assign in_load   = (state == ST_LOAD);
    assign cnt_last  = (busy_cnt == CNT_W'(EFF_CYCLES - 1));
    assign walk_end  = (walk_idx == (IDX_W + 1)'(ENTRIES));

    // Request gating: priority is abort, then restart, then commit, then byte.
    always_comb begin
        buf_open  = !busy && txn_start && !abort;
        buf_clear = in_load && abort;
        buf_load  = in_load && byte_vld && !abort && !txn_start && !commit;
        go        = in_load && commit && !abort && !txn_start && any_loaded;
    end

    // Control state: load phase, then walk, then timed hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (buf_open) state <= ST_LOAD;
                ST_LOAD: begin
                    if (abort)          state <= ST_IDLE;
                    else if (txn_start) state <= ST_LOAD;
                    else if (commit)    state <= any_loaded ? ST_WALK : ST_IDLE;
                end
                ST_WALK: begin
                    if (cnt_last)      state <= ST_IDLE;
                    else if (walk_end) state <= ST_HOLD;
                end
                default: if (cnt_last) state <= ST_IDLE;
            endcase
        end
    end

    // Busy timer: counts the cycles since commit while busy is high.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (go)   busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
    end

    // Walk counter: visits slots 0..ENTRIES-1, then one extra step to drain.
    always_ff @(posedge clk) begin
        if (!rst_n)                                walk_idx <= '0;
        else if (go)                               walk_idx <= '0;
        else if (state == ST_WALK && !walk_end)    walk_idx <= walk_idx + 1'b1;
    end

    // Merge stage: keep the slot and its staged byte beside the array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_use <= 1'b0;
            pend_idx <= '0;
            pend_new <= '0;
        end else begin
            pend_vld <= (state == ST_WALK) && !walk_end;
            pend_use <= buf_rd_vld;
            pend_idx <= walk_idx[IDX_W-1:0];
            pend_new <= buf_rd_data;
        end
    end

    assign walk_slot   = walk_idx[IDX_W-1:0];
    assign arr_wr_en   = pend_vld;
    assign arr_wr_addr = {page, pend_idx};
    assign arr_wr_data = pend_use ? pend_new : old_data;

    // R5: busy ends right after the last counted cycle
    a_r5_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_last) |=> !busy);

    // R5: busy does not drop before the count is reached
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cnt_last) |=> busy);

    // R5: busy only rises after a commit request
    a_r5_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    // R6: busy never starts from an empty buffer
    a_r6_no_busy_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(any_loaded));

    // R4: the array is only written inside a busy period
    a_r4_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> busy);

    // R4: merged writes cover the page in ascending slot order
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && $past(arr_wr_en)) |-> pend_idx == IDX_W'($past(pend_idx) + 1'b1));

    // R7: nothing is staged or opened while busy
    a_r7_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!buf_load && !buf_open));
endmodule

// File: rtl/page_merge_prog.sv
// Top level of the page merge program engine.
// It connects the staging buffer, the controller/walker and the array.
// Port A of the array feeds the merge. Port B is the external read port.
// PAGE_AW = 9 gives the full 131,072-byte array; the default is smaller.
module page_merge_prog #(
    parameter int PAGE_AW      = 3,
    parameter int IDX_W        = 8,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 300,
    localparam int ADDR_W      = PAGE_AW + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit,
    input  logic              abort,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic               buf_open, buf_clear, buf_load;
    logic [IDX_W-1:0]   walk_slot;
    logic [DATA_W-1:0]  buf_rd_data, old_data, wr_data;
    logic               buf_rd_vld, any_loaded, wr_en;
    logic [PAGE_AW-1:0] page;
    logic [ADDR_W-1:0]  wr_addr;

    page_buffer #(.PAGE_AW(PAGE_AW), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .open_i(buf_open), .start_addr(start_addr), .clear_i(buf_clear),
        .load_i(buf_load), .load_data(byte_data),
        .rd_idx(walk_slot), .rd_data(buf_rd_data), .rd_vld(buf_rd_vld),
        .page_o(page), .any_loaded_o(any_loaded)
    );

    merge_walker #(.PAGE_AW(PAGE_AW), .IDX_W(IDX_W), .DATA_W(DATA_W),
                   .WRITE_CYCLES(WRITE_CYCLES)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .txn_start(txn_start), .abort(abort), .commit(commit), .byte_vld(byte_vld),
        .any_loaded(any_loaded), .buf_rd_data(buf_rd_data), .buf_rd_vld(buf_rd_vld),
        .old_data(old_data), .page(page),
        .buf_open(buf_open), .buf_clear(buf_clear), .buf_load(buf_load),
        .walk_slot(walk_slot), .arr_wr_en(wr_en), .arr_wr_addr(wr_addr),
        .arr_wr_data(wr_data), .busy(busy)
    );

    page_array #(.PAGE_AW(PAGE_AW), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ra_addr({page, walk_slot}), .ra_data(old_data),
        .rb_addr(rd_addr), .rb_data(rd_data)
    );
endmodule

// File: tb/test_page_merge_prog.sv
module test_page_merge_prog;
    localparam int PAGE_AW = 3;
    localparam int IDX_W   = 8;
    localparam int ADDR_W  = PAGE_AW + IDX_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int SLOTS   = 1 << IDX_W;
    localparam int WCYC    = 300;
    localparam int EXP_BUSY = (WCYC < SLOTS + 2) ? SLOTS + 2 : WCYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_start = 1'b0, byte_vld = 1'b0, commit = 1'b0, abort = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0, rd_addr = '0;
    logic [7:0] byte_data = '0;
    logic busy;
    logic [7:0] rd_data;

    int nchk = 0, nfail = 0;

    logic [7:0] exp_mem [DEPTH];
    logic [7:0] m_buf [SLOTS];
    bit         m_mask [SLOTS];
    bit         m_open = 0, m_busy = 0;
    int         m_page = 0, m_idx = 0;

    page_merge_prog #(.PAGE_AW(PAGE_AW), .IDX_W(IDX_W), .DATA_W(8), .WRITE_CYCLES(WCYC))
        i_page_merge_prog (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .commit(commit), .abort(abort),
        .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data));

    always #10 clk = ~clk;

    task automatic report(string req, bit ok, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic open_txn(int addr);
        @(negedge clk); txn_start = 1'b1; start_addr = ADDR_W'(addr);
        @(negedge clk); txn_start = 1'b0;
        if (!m_busy) begin
            m_open = 1; m_page = addr >> IDX_W; m_idx = addr % SLOTS;
            for (int i = 0; i < SLOTS; i++) m_mask[i] = 0;
        end
    endtask

    task automatic send_byte(logic [7:0] d);
        @(negedge clk); byte_vld = 1'b1; byte_data = d;
        @(negedge clk); byte_vld = 1'b0;
        if (m_open && !m_busy) begin
            m_buf[m_idx] = d; m_mask[m_idx] = 1; m_idx = (m_idx + 1) % SLOTS;
        end
    endtask

    task automatic do_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        m_open = 0;
    endtask

    // Pulse commit, update the model and return the number of busy cycles seen.
    task automatic commit_measure(string req);
        int n = 0;
        int expc = 0;
        bit any = 0;
        for (int i = 0; i < SLOTS; i++) any |= m_mask[i];
        if (m_open && any) begin
            expc = EXP_BUSY;
            for (int i = 0; i < SLOTS; i++)
                if (m_mask[i]) exp_mem[m_page * SLOTS + i] = m_buf[i];
        end
        m_open = 0;
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        while (busy && n < EXP_BUSY + 20) begin
            n++;
            @(negedge clk);
        end
        report(req, n == expc, n, expc);
    endtask

    task automatic check_array(string req);
        int bad = 0, first = 0, fa = 0, fe = 0;
        @(negedge clk); rd_addr = '0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            if (rd_data !== exp_mem[a]) begin
                if (bad == 0) begin first = a; fa = rd_data; fe = exp_mem[a]; end
                bad++;
            end
            if (a + 1 < DEPTH) rd_addr = ADDR_W'(a + 1);
        end
        nchk++;
        if (bad != 0) begin
            nfail++;
            $display("FAIL %s: %0d bytes differ, first at %0d actual %0d expected %0d",
                     req, bad, first, fa, fe);
        end
    endtask

    initial begin
        #(20 * 190000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        for (int i = 0; i < SLOTS; i++) m_mask[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: erased array, busy low
        report("R1 busy after reset", busy == 1'b0, busy, 0);
        check_array("R1/R9 erased array via read port");

        // R2/R4/R5: single byte in page 2, slot 10
        open_txn(2 * SLOTS + 10);
        send_byte(8'h5A);
        commit_measure("R5 busy length single byte");
        check_array("R2/R4 single byte merge");

        // R4: full page from slot 0
        open_txn(5 * SLOTS);
        for (int i = 0; i < SLOTS; i++) send_byte(8'(i * 3 + 1));
        commit_measure("R5 busy length full page");
        check_array("R4 full page");

        // R3: wrap from slot 250 with 260 bytes
        open_txn(1 * SLOTS + 250);
        for (int i = 0; i < 260; i++) send_byte(8'(i ^ 8'hA5));
        commit_measure("R3 busy length wrap");
        check_array("R3 wrap within page");

        // R2/R4: sweep every page with its own start slot and length
        for (int p = 0; p < (1 << PAGE_AW); p++) begin
            open_txn(p * SLOTS + ((p * 37) % SLOTS));
            for (int k = 0; k < p * 41 + 1; k++) send_byte(8'(p * 16 + k * 5));
            commit_measure("R5 busy length sweep");
        end
        check_array("R2/R4 page sweep");

        // R6: empty commit
        open_txn(3 * SLOTS + 7);
        commit_measure("R6 empty commit no busy");
        // R6: abort then commit
        open_txn(4 * SLOTS + 1);
        for (int k = 0; k < 5; k++) send_byte(8'h11);
        do_abort();
        commit_measure("R6 abort then commit no busy");
        check_array("R6 array unchanged");

        // R8: restart drops earlier staged bytes
        open_txn(3 * SLOTS + 20);
        for (int k = 0; k < 8; k++) send_byte(8'h77);
        open_txn(4 * SLOTS + 200);
        for (int k = 0; k < 70; k++) send_byte(8'(k + 100));
        commit_measure("R8 busy length after restart");
        check_array("R8 only latest transaction programmed");

        // R7: requests while busy are ignored
        open_txn(6 * SLOTS);
        for (int k = 0; k < 4; k++) send_byte(8'h3C);
        for (int i = 0; i < SLOTS; i++) if (m_mask[i]) exp_mem[6 * SLOTS + i] = m_buf[i];
        m_open = 0;
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        m_busy = 1;
        report("R7 busy raised", busy == 1'b1, busy, 1);
        open_txn(7 * SLOTS + 9);
        for (int k = 0; k < 6; k++) send_byte(8'hC3);
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        while (busy) @(negedge clk);
        m_busy = 0;
        commit_measure("R7 no transaction left open");
        check_array("R7 requests during busy ignored");

        // R10: bytes and commit with no open transaction
        for (int k = 0; k < 4; k++) send_byte(8'h99);
        commit_measure("R10 stray commit no busy");
        check_array("R10 stray bytes ignored");

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule